// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits in front of a 10-bit successive-approximation converter. Software uses a small register port to program it. A control register holds an enable, a 3-bit input select, a sync-gate enable and a start bit. A data register returns the last result together with a valid flag. A conversion is launched only when a control write moves the start bit from 0 to 1 while the same write sets the enable. Software therefore writes enable plus input select first, then writes the same value again with start set. The block then raises a request toward the converter and holds it until the converter answers with a done strobe and the result. The result is captured, the valid flag is set, and a one-cycle completion event is sent to the interrupt unit.

When the sync-gate bit is part of the launching write, the request is held back until a fresh rising edge appears on an external sync pin. That edge is seen after the pin passes through a synchronizer. Writing the control register with the enable clear shuts the converter off. This also abandons any conversion that is waiting for sync or is waiting for the converter.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, the control register and the data register both read 0x0000, and `cnv_req` and `done_evt` are low.
- R2: The control register keeps enable at bit 15, start at bit 7, input select at bits 4:2 and sync-gate at bit 0. These bits read back as written, and all other bits read as 0.
- R3: A control write that sets enable and changes start from 0 to 1, with sync-gate clear, raises `cnv_req` in the cycle after the write edge. `cnv_chan` carries the written select code: codes 0 to 3 are the four panel plate inputs and codes 4 to 7 are the auxiliary inputs.
- R4: A write that sets start while enable is clear starts no conversion. `cnv_req` stays low and the data register keeps its value.
- R5: A write with start set, made while the stored start bit is already 1, starts no new conversion.
- R6: Launching a conversion clears the valid flag (data register bit 15) from the cycle after the launching write.
- R7: `cnv_req` stays high until `cnv_done` is sampled high. At that edge the block captures `cnv_data`, and from the next cycle the data register reads valid=1 in bit 15 and the result in bits 9:0, with bits 14:10 at 0, and `cnv_req` is low.
- R8: `done_evt` is high for exactly the one cycle after the edge that captures a result.
- R9: With sync-gate set in the launching write, `cnv_req` stays low until the sync pin rises. With the default two synchronizer stages, it rises after the third clock edge that samples the pin high.
- R10: A sync pin that is already high when the conversion is launched does not release it. Only a later low-to-high transition does.
- R11: A control write with enable clear cancels a conversion that is waiting or in progress. `cnv_req` drops after that edge, and a later `cnv_done` captures nothing and raises no event.
- R12: `cnv_done` is ignored while no conversion is outstanding. The data register is unchanged and `done_evt` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (7) | Register address for writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`; combinational |
| sync_pin | input | 1 | Asynchronous external sync input |
| cnv_req | output | 1 | Conversion request to the converter |
| cnv_chan | output | 3 | Input select code presented to the converter |
| cnv_done | input | 1 | Converter strobe: result is ready |
| cnv_data | input | 10 | Converter result |
| done_evt | output | 1 | One-cycle completion event to the interrupt unit |

## Verification
Each result has a fixed delay after its stimulus:
- Request, cleared valid flag and cancellation show up one edge after the write that causes them.
- A captured result and `done_evt` show up one edge after `cnv_done`.
- A sync-gated request shows up three edges after the pin is first sampled high.

The bench drives inputs just after a rising edge and samples just after the following edge or edges. It checks the gated request both one cycle early (must still be low) and on its due cycle (must be high), so an extra or missing pipeline stage is caught. Results are read back through the register port in the cycle they become due.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W    = 16;
    localparam int RES_W    = 10;
    localparam int SEL_W    = 3;

    localparam int EN_BIT   = 15;
    localparam int GO_BIT   = 7;
    localparam int SEL_LSB  = 2;
    localparam int SYNC_BIT = 0;
    localparam int VLD_BIT  = 15;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             sync_en;
        logic             go;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_SYNC = 2'd1,
        ST_REQ       = 2'd2
    } seq_state_e;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.en      = w[EN_BIT];
        c.sel     = w[SEL_LSB +: SEL_W];
        c.sync_en = w[SYNC_BIT];
        c.go      = w[GO_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                    = '0;
        w[EN_BIT]            = c.en;
        w[SEL_LSB +: SEL_W]  = c.sel;
        w[SYNC_BIT]          = c.sync_en;
        w[GO_BIT]            = c.go;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] data_to_word(input logic v,
                                                      input logic [RES_W-1:0] r);
        logic [REG_W-1:0] w;
        w              = '0;
        w[RES_W-1:0]   = r;
        w[VLD_BIT]     = v;
        return w;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl_reg.sv
module adc_seq_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             launch,
    output logic             launch_sync,
    output logic             cancel
);
    ctrl_t ctrl_new;

    always_comb begin
        ctrl_new    = ctrl_from_word(wdata);
        // start edge: stored start low, new start high, enable in same write
        launch      = wr_ctrl && ctrl_new.en && ctrl_new.go && !ctrl_q.go;
        launch_sync = ctrl_new.sync_en;
        cancel      = wr_ctrl && !ctrl_new.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_new;
        end
    end

    // R4: a launch can never come from a write that turns the converter off
    a_r4_no_launch_on_cancel: assert property (@(posedge clk) disable iff (rst)
        cancel |-> !launch);

endmodule

// File: rtl/adc_seq_sync_edge.sv
module adc_seq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] && !prev_q;

    // R10: a detected edge is never reported on two consecutive cycles
    a_r10_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             launch_sync,
    input  logic             cancel,
    input  logic             sync_rise,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_data,
    output logic             cnv_req,
    output logic             valid_q,
    output logic [RES_W-1:0] result_q,
    output logic             done_evt
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            valid_q  <= 1'b0;
            result_q <= '0;
            done_evt <= 1'b0;
        end else begin
            done_evt <= 1'b0;
            if (cancel) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (launch) begin
                            valid_q <= 1'b0;
                            state_q <= launch_sync ? ST_WAIT_SYNC : ST_REQ;
                        end
                    end
                    ST_WAIT_SYNC: begin
                        if (sync_rise) state_q <= ST_REQ;
                    end
                    ST_REQ: begin
                        if (cnv_done) begin
                            result_q <= cnv_data;
                            valid_q  <= 1'b1;
                            done_evt <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign cnv_req = (state_q == ST_REQ);

    // R7: request holds until the converter answers or software cancels
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (cnv_req && !cnv_done && !cancel) |=> cnv_req);

    // R7: every completion event comes with a valid result
    a_r7_evt_valid: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> valid_q);

    // R8: completion event lasts one cycle
    a_r8_evt_pulse: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !done_evt);

    // R6: launch from idle clears the valid flag
    a_r6_valid_clear: assert property (@(posedge clk) disable iff (rst)
        (launch && state_q == ST_IDLE) |=> !valid_q);

    // R9: no request while waiting for a sync edge that has not come
    a_r9_wait_gate: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_SYNC && !sync_rise) |=> !cnv_req);

    // R12: a done strobe with nothing outstanding raises no event
    a_r12_idle_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !done_evt);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h66,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 7'h68,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              sync_pin,
    output logic              cnv_req,
    output logic [SEL_W-1:0]  cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_data,
    output logic              done_evt
);
    ctrl_t            ctrl_q;
    logic             wr_ctrl;
    logic             launch;
    logic             launch_sync;
    logic             cancel;
    logic             sync_rise;
    logic             valid_q;
    logic [RES_W-1:0] result_q;

    assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);

    adc_seq_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .wdata       (reg_wdata),
        .ctrl_q      (ctrl_q),
        .launch      (launch),
        .launch_sync (launch_sync),
        .cancel      (cancel)
    );

    adc_seq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (sync_pin),
        .rise      (sync_rise)
    );

    adc_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_sync (launch_sync),
        .cancel      (cancel),
        .sync_rise   (sync_rise),
        .cnv_done    (cnv_done),
        .cnv_data    (cnv_data),
        .cnv_req     (cnv_req),
        .valid_q     (valid_q),
        .result_q    (result_q),
        .done_evt    (done_evt)
    );

    assign cnv_chan = ctrl_q.sel;

    always_comb begin
        if (reg_addr == CTRL_ADDR)      reg_rdata = ctrl_to_word(ctrl_q);
        else if (reg_addr == DATA_ADDR) reg_rdata = data_to_word(valid_q, result_q);
        else                            reg_rdata = '0;
    end

    // R4: a request only ever begins while the stored enable is set
    a_r4_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_req) |-> ctrl_q.en);

    // R11: a disabling write drops the request on the next cycle
    a_r11_cancel_drops: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !cnv_req);

endmodule

// File: tb/adc_conv_sequencer_tb_top.sv
`timescale 1ns/100ps
module adc_conv_sequencer_tb_top;

    localparam logic [6:0] A_CTRL = 7'h66;
    localparam logic [6:0] A_DATA = 7'h68;

    // fields: select[13:11], sync-gate[10], result[9:0]
    localparam logic [13:0] VEC_TAB [6] = '{
        {3'd0, 1'b0, 10'h000},
        {3'd3, 1'b0, 10'h3FF},
        {3'd5, 1'b1, 10'h155},
        {3'd7, 1'b0, 10'h2AA},
        {3'd2, 1'b1, 10'h001},
        {3'd4, 1'b0, 10'h200}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sync_pin = 1'b0;
    logic        cnv_req;
    logic [2:0]  cnv_chan;
    logic        cnv_done = 1'b0;
    logic [9:0]  cnv_data = '0;
    logic        done_evt;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_conv_sequencer dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sync_pin  (sync_pin),
        .cnv_req   (cnv_req),
        .cnv_chan  (cnv_chan),
        .cnv_done  (cnv_done),
        .cnv_data  (cnv_data),
        .done_evt  (done_evt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic finish_conv(input string req, input logic [9:0] res);
        logic [15:0] d;
        cnv_done = 1'b1;
        cnv_data = res;
        tick();
        cnv_done = 1'b0;
        cnv_data = ~res;
        chk({req, " req low after done"}, cnv_req, 0);
        chk({req, " R8 event"}, done_evt, 1);
        rd(A_DATA, d);
        chk({req, " R7 data"}, d, {1'b1, 5'b0, res});
        tick();
        chk({req, " R8 event one cycle"}, done_evt, 0);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        tick();
        tick();
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 16'h0000);
        rd(A_DATA, d); chk("R1 data", d, 16'h0000);
        chk("R1 req", cnv_req, 0);
        chk("R1 evt", done_evt, 0);

        // R2 readback: all bits set except start
        wr(A_CTRL, 16'hFF7F);
        rd(A_CTRL, d); chk("R2 readback", d, 16'h801D);
        chk("R2 no launch without start", cnv_req, 0);
        wr(A_CTRL, 16'h0000);

        // table walk: R3 R6 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            logic [13:0] v;
            logic [15:0] w;
            v = VEC_TAB[i];
            w = 16'h8000 | (16'(v[13:11]) << 2) | 16'(v[10]);
            wr(A_CTRL, w);
            wr(A_CTRL, w | 16'h0080);
            chk("R3 chan", cnv_chan, v[13:11]);
            rd(A_DATA, d); chk("R6 valid cleared", d[15], 0);
            if (v[10]) begin
                chk("R9 held for sync", cnv_req, 0);
                sync_pin = 1'b1;
                tick(); tick();
                chk("R9 not yet", cnv_req, 0);
                tick();
                chk("R9 released", cnv_req, 1);
                sync_pin = 1'b0;
            end else begin
                chk("R3 req", cnv_req, 1);
            end
            tick(); tick();
            chk("R7 req held", cnv_req, 1);
            finish_conv("R7", v[9:0]);
        end

        // R5: start already set, rewrite does not relaunch
        wr(A_CTRL, 16'h8090);
        chk("R5 no relaunch", cnv_req, 0);
        tick();
        chk("R5 still idle", cnv_req, 0);
        rd(A_DATA, d); chk("R5 data kept", d, 16'h8200);

        // R4: start while disabled
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, 16'h0088);
        chk("R4 no req", cnv_req, 0);
        tick(); tick();
        chk("R4 still no req", cnv_req, 0);
        rd(A_DATA, d); chk("R4 data kept", d, 16'h8200);

        // R12: stray done while idle
        cnv_done = 1'b1; cnv_data = 10'h0AB;
        tick();
        cnv_done = 1'b0;
        chk("R12 no event", done_evt, 0);
        rd(A_DATA, d); chk("R12 data unchanged", d, 16'h8200);

        // R11: cancel an active conversion
        wr(A_CTRL, 16'h8000);
        wr(A_CTRL, 16'h8080);
        chk("R11 launched", cnv_req, 1);
        wr(A_CTRL, 16'h0000);
        chk("R11 req dropped", cnv_req, 0);
        cnv_done = 1'b1; cnv_data = 10'h111;
        tick();
        cnv_done = 1'b0;
        chk("R11 no event", done_evt, 0);
        rd(A_DATA, d); chk("R11 nothing captured", d, 16'h0200);

        // R10: pin already high at launch does not release
        sync_pin = 1'b1;
        repeat (4) tick();
        wr(A_CTRL, 16'h8001);
        wr(A_CTRL, 16'h8081);
        repeat (5) tick();
        chk("R10 level ignored", cnv_req, 0);
        sync_pin = 1'b0;
        repeat (3) tick();
        chk("R10 still waiting", cnv_req, 0);
        sync_pin = 1'b1;
        tick(); tick();
        chk("R10 not yet", cnv_req, 0);
        tick();
        chk("R10 fresh edge releases", cnv_req, 1);
        finish_conv("R10", 10'h0C3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule